// File: doc/BRIEF.md
# Asynchronous Serial Port with Three-Sample Voting Receiver

This block is a full-duplex asynchronous serial port. Frames are one start bit (0), eight data bits sent least significant bit first, and one stop bit (1). The line idles high. An 8-bit divisor input sets the bit rate: an oversampling tick fires once every `baud_div + 1` clocks, and one bit lasts sixteen ticks. The transmitter and the receiver each keep a private tick generator. That generator is held while its side is idle, so bit timing is always measured from the start of a frame.

Transmit data enters through a valid/ready stream. `tx_ready` is the data-register-empty status. A byte is accepted in any cycle where `tx_valid` and `tx_ready` are both high. If the transmitter is idle, the byte goes straight into the shift register and `tx_ready` stays high. If a frame is in progress, the byte waits in a one-entry holding register and `tx_ready` drops until that byte moves to the shift register at the end of the current stop bit.

Received bytes leave through a valid/ready stream. `rx_valid` is the receive-complete status. It holds its byte until the consumer asserts `rx_ready`. The receiver never waits. A byte that completes while the previous one is unread replaces it and sets the overrun flag. Clearing overrun takes two steps: a status-read strobe while overrun is set, then a data read. Three interrupt requests are each gated by their own enable and by a global enable.

Top module: `uart_mv_top`

## Requirements
- R1: Every transmitted bit occupies exactly 16*(baud_div+1) clock cycles.
- R2: A transmitted frame is a 0 start bit, then data bits 0 to 7 in that order, then a 1 stop bit. `txd` is 1 whenever no frame is being sent.
- R3: A byte accepted while the transmitter is idle drives `txd` to 0 at the same clock edge that accepts it, and `tx_ready` stays 1.
- R4: A byte accepted during a frame drops `tx_ready` at the accepting edge. `tx_ready` stays 0 until the current stop bit ends. The held byte's start bit then begins at that edge, with no idle gap.
- R5: `tx_done` rises when a stop bit ends with no byte waiting. It falls when a byte is accepted.
- R6: Each received bit takes the value held by at least two of its samples at oversampling ticks 8, 9 and 10, counted from the start of the bit. A one-clock glitch anywhere in a bit does not change the received byte.
- R7: A falling edge on an idle line starts reception. If the start bit's vote is 1, the receiver returns to idle and delivers no byte.
- R8: If the stop bit's vote is 0, the byte is still delivered, but with `rx_ferr` = 1. `rx_ferr` clears when that byte is read.
- R9: `rx_valid` stays 1, and `rx_data` stays stable, until a cycle with `rx_ready` = 1. That cycle clears `rx_valid`.
- R10: A byte that completes while `rx_valid` is still 1 sets `rx_ovr`, and the new byte replaces the old one.
- R11: `rx_ovr` clears only on a data read that follows a `stat_rd` strobe issued while `rx_ovr` was set. A data read with no such strobe leaves it set.
- R12: `irq_rx`, `irq_txe` and `irq_txd` equal `rx_valid`, `tx_ready` and `tx_done` respectively, each ANDed with its own enable and with `gie`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_div | input | 8 | Divisor; one tick every baud_div+1 clocks |
| tx_data | input | 8 | Byte to transmit |
| tx_valid | input | 1 | Transmit byte offered |
| tx_ready | output | 1 | Data register empty; byte accepted when tx_valid is also 1 |
| txd | output | 1 | Serial output line |
| tx_done | output | 1 | Transmit complete |
| rxd | input | 1 | Serial input line (asynchronous) |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | Receive complete; byte held until read |
| rx_ready | input | 1 | Consumer reads the byte |
| rx_ferr | output | 1 | Framing error of the held byte |
| rx_ovr | output | 1 | Overrun flag |
| stat_rd | input | 1 | Status-read strobe, first step of the overrun clear |
| gie | input | 1 | Global interrupt enable |
| ie_rx | input | 1 | Receive-complete interrupt enable |
| ie_txe | input | 1 | Data-register-empty interrupt enable |
| ie_txd | input | 1 | Transmit-complete interrupt enable |
| irq_rx | output | 1 | Receive-complete request |
| irq_txe | output | 1 | Data-register-empty request |
| irq_txd | output | 1 | Transmit-complete request |

## Verification
`txd` changes on the edge that accepts an idle write. Every later bit boundary falls 16*(baud_div+1) edges after that, so the bench counts falling edges from the accept and samples each bit at its centre. It reads `tx_ready` and `tx_done` on the falling edge just after the boundary where they must have changed. The receiver delivers its byte during the stop bit, a few clocks after the third stop sample, which is delayed by a two-flop synchroniser. The bench therefore checks `rx_valid`, `rx_data` and the flags after the full frame plus an idle gap. A read takes effect on the next edge, so results are checked on the following falling edge.

// File: rtl/uart_mv_pkg.sv
package uart_mv_pkg;
  parameter int unsigned OSR   = 16;
  localparam int unsigned OSR_W = $clog2(OSR);

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart_mv_tick.sv
module uart_mv_tick #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             hold,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (hold)        cnt <= div;
    else if (cnt == '0)   cnt <= div;
    else                  cnt <= cnt - 1'b1;
  end

  assign tick = !hold && (cnt == '0);

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && div != '0 && $stable(div)) |=> !tick); // R1
endmodule

// File: rtl/uart_mv_tx.sv
module uart_mv_tx
  import uart_mv_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic [DW-1:0]    wdata,
  input  logic             wvalid,
  output logic             wready,
  output logic             txd,
  output logic             done
);
  localparam int unsigned BN_W = $clog2(DW + 2);

  logic             busy, pend, tick;
  logic [DW-1:0]    pend_data;
  logic [DW:0]      shreg;
  logic [BN_W-1:0]  bitn;
  logic [OSR_W-1:0] phase;
  logic             accept, bit_end, last;

  uart_mv_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div), .hold(!busy), .tick(tick)
  );

  assign wready  = !pend;
  assign accept  = wvalid && wready;
  assign bit_end = tick && (phase == OSR_W'(OSR - 1));
  assign last    = (bitn == BN_W'(DW + 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pend      <= 1'b0;
      pend_data <= '0;
      shreg     <= '0;
      bitn      <= '0;
      phase     <= '0;
      txd       <= 1'b1;
      done      <= 1'b0;
    end else if (!busy) begin
      if (accept) begin
        busy  <= 1'b1;
        txd   <= 1'b0;
        shreg <= {1'b1, wdata};
        bitn  <= '0;
        phase <= '0;
        done  <= 1'b0;
      end
    end else begin
      if (bit_end)   phase <= '0;
      else if (tick) phase <= phase + 1'b1;
      if (accept) begin
        pend      <= 1'b1;
        pend_data <= wdata;
        done      <= 1'b0;
      end
      if (bit_end) begin
        if (last) begin
          if (pend) begin
            txd   <= 1'b0;
            shreg <= {1'b1, pend_data};
            pend  <= 1'b0;
            bitn  <= '0;
          end else if (accept) begin
            txd   <= 1'b0;
            shreg <= {1'b1, wdata};
            pend  <= 1'b0;
            bitn  <= '0;
          end else begin
            busy <= 1'b0;
            txd  <= 1'b1;
            done <= 1'b1;
          end
        end else begin
          txd   <= shreg[0];
          shreg <= {1'b1, shreg[DW:1]};
          bitn  <= bitn + 1'b1;
        end
      end
    end
  end

  AST_TX_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd); // R2
  AST_TX_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> wready); // R3
  AST_TX_PEND_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !wready |-> busy); // R4
  AST_TX_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R5
endmodule

// File: rtl/uart_mv_rx.sv
module uart_mv_rx
  import uart_mv_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             rxd,
  output logic [DW-1:0]    data,
  output logic             valid,
  input  logic             ready,
  output logic             ferr,
  output logic             ovr,
  input  logic             stat_rd
);
  localparam int unsigned BN_W = (DW > 1) ? $clog2(DW) : 1;

  rx_state_e        state;
  logic             s1, s2, prev, tick;
  logic [1:0]       smp;
  logic [DW-1:0]    shreg;
  logic [BN_W-1:0]  bitn;
  logic [OSR_W-1:0] phase;
  logic             armed;
  logic             fall, decide, bit_end, vote, rd_fire;

  uart_mv_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div(div), .hold(state == RX_IDLE), .tick(tick)
  );

  assign fall    = prev && !s2;
  assign decide  = tick && (phase == OSR_W'(OSR / 2 + 1));
  assign bit_end = tick && (phase == OSR_W'(OSR - 1));
  assign vote    = (smp[0] & smp[1]) | (smp[0] & s2) | (smp[1] & s2);
  assign rd_fire = valid && ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1 <= 1'b1; s2 <= 1'b1; prev <= 1'b1;
    end else begin
      s1 <= rxd; s2 <= s1; prev <= s2;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= RX_IDLE;
      phase <= '0;
      bitn  <= '0;
      smp   <= '0;
      shreg <= '0;
      data  <= '0;
      valid <= 1'b0;
      ferr  <= 1'b0;
      ovr   <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (stat_rd && ovr) armed <= 1'b1;
      if (rd_fire) begin
        valid <= 1'b0;
        ferr  <= 1'b0;
        if (armed) begin
          ovr   <= 1'b0;
          armed <= 1'b0;
        end
      end

      if (state == RX_IDLE) begin
        phase <= '0;
        if (fall) state <= RX_START;
      end else begin
        if (bit_end)   phase <= '0;
        else if (tick) phase <= phase + 1'b1;
        if (tick && phase == OSR_W'(OSR / 2 - 1)) smp[0] <= s2;
        if (tick && phase == OSR_W'(OSR / 2))     smp[1] <= s2;

        unique case (state)
          RX_START: begin
            if (decide && vote) state <= RX_IDLE;
            else if (bit_end) begin
              state <= RX_DATA;
              bitn  <= '0;
            end
          end
          RX_DATA: begin
            if (decide) shreg <= {vote, shreg[DW-1:1]};
            if (bit_end) begin
              if (bitn == BN_W'(DW - 1)) state <= RX_STOP;
              else                        bitn  <= bitn + 1'b1;
            end
          end
          RX_STOP: begin
            if (decide) begin
              data  <= shreg;
              valid <= 1'b1;
              ferr  <= !vote;
              if (valid && !rd_fire) ovr <= 1'b1;
              state <= RX_IDLE;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  AST_FERR_WITH_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ferr |-> valid); // R8
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && !ready) |=> valid); // R9
  AST_OVR_RISE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovr) |-> valid); // R10
  AST_OVR_CLEAR_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovr) |-> $past(ready && valid)); // R11
endmodule

// File: rtl/uart_mv_top.sv
module uart_mv_top #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] baud_div,
  input  logic [DW-1:0]    tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic             txd,
  output logic             tx_done,
  input  logic             rxd,
  output logic [DW-1:0]    rx_data,
  output logic             rx_valid,
  input  logic             rx_ready,
  output logic             rx_ferr,
  output logic             rx_ovr,
  input  logic             stat_rd,
  input  logic             gie,
  input  logic             ie_rx,
  input  logic             ie_txe,
  input  logic             ie_txd,
  output logic             irq_rx,
  output logic             irq_txe,
  output logic             irq_txd
);
  uart_mv_tx #(.DW(DW), .DIV_W(DIV_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .div(baud_div),
    .wdata(tx_data), .wvalid(tx_valid), .wready(tx_ready),
    .txd(txd), .done(tx_done)
  );

  uart_mv_rx #(.DW(DW), .DIV_W(DIV_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .div(baud_div), .rxd(rxd),
    .data(rx_data), .valid(rx_valid), .ready(rx_ready),
    .ferr(rx_ferr), .ovr(rx_ovr), .stat_rd(stat_rd)
  );

  assign irq_rx  = gie && ie_rx  && rx_valid;
  assign irq_txe = gie && ie_txe && tx_ready;
  assign irq_txd = gie && ie_txd && tx_done;

  AST_IRQ_RX_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (gie && ie_rx && $rose(rx_valid)) |-> irq_rx); // R12
endmodule

// File: tb/uart_mv_top_tb.sv
module uart_mv_top_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] baud_div = 8'd0;
  logic [7:0] tx_data = 8'd0;
  logic       tx_valid = 1'b0, rxd = 1'b1, rx_ready = 1'b0, stat_rd = 1'b0;
  logic       gie = 1'b0, ie_rx = 1'b0, ie_txe = 1'b0, ie_txd = 1'b0;
  logic       tx_ready, txd, tx_done, rx_valid, rx_ferr, rx_ovr;
  logic       irq_rx, irq_txe, irq_txd;
  logic [7:0] rx_data;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  uart_mv_top u_dut (
    .clk(clk), .rst_n(rst_n), .baud_div(baud_div), .tx_data(tx_data),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .txd(txd), .tx_done(tx_done),
    .rxd(rxd), .rx_data(rx_data), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_ferr(rx_ferr), .rx_ovr(rx_ovr), .stat_rd(stat_rd), .gie(gie),
    .ie_rx(ie_rx), .ie_txe(ie_txe), .ie_txd(ie_txd), .irq_rx(irq_rx),
    .irq_txe(irq_txe), .irq_txd(irq_txd)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Current negedge is m=0 (start bit); sample each bit centre.
  task automatic grab_frame(input int dv, output logic [9:0] bits);
    int cur = 0;
    for (int k = 0; k < 10; k++) begin
      int tgt = 16 * (dv + 1) * k + 8 * (dv + 1);
      repeat (tgt - cur) @(negedge clk);
      cur = tgt;
      bits[k] = txd;
    end
    repeat (160 * (dv + 1) - cur) @(negedge clk);
  endtask

  task automatic tx_one(input logic [7:0] d, input int dv);
    logic [9:0] bits;
    @(negedge clk);
    tx_data = d; tx_valid = 1'b1;
    @(negedge clk);
    tx_valid = 1'b0;
    check("R3 txd low on accept", {31'd0, txd}, 32'd0);
    check("R3 tx_ready stays high", {31'd0, tx_ready}, 32'd1);
    grab_frame(dv, bits);
    check("R1 R2 frame bits", {22'd0, bits}, {22'd0, 1'b1, d, 1'b0});
    check("R5 tx_done after stop", {30'd0, tx_done, txd}, 32'd3);
  endtask

  task automatic rx_one(input logic [7:0] d, input int dv, input bit glitch, input bit badstop);
    for (int k = 0; k < 10; k++) begin
      logic v;
      v = (k == 0) ? 1'b0 : (k == 9) ? ~badstop : d[k-1];
      for (int c = 0; c < 16 * (dv + 1); c++) begin
        @(negedge clk);
        rxd = (glitch && c == 9 * (dv + 1)) ? ~v : v;
      end
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (16 * (dv + 1)) @(negedge clk);
  endtask

  task automatic rd_pulse();
    @(negedge clk); rx_ready = 1'b1;
    @(negedge clk); rx_ready = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [9:0] bits;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 reset txd", {31'd0, txd}, 32'd1);
    check("R3 reset tx_ready", {31'd0, tx_ready}, 32'd1);
    check("R5 reset tx_done", {31'd0, tx_done}, 32'd0);
    check("R9 reset rx_valid", {31'd0, rx_valid}, 32'd0);
    check("R10 reset flags", {30'd0, rx_ferr, rx_ovr}, 32'd0);

    // R12 data-register-empty request gating
    ie_txe = 1'b1; gie = 1'b1; @(negedge clk);
    check("R12 irq_txe enabled", {31'd0, irq_txe}, 32'd1);
    gie = 1'b0; @(negedge clk);
    check("R12 irq_txe global off", {31'd0, irq_txe}, 32'd0);

    // R1 R2 R3 R5 full sweep at divisor 0
    for (int b = 0; b < 256; b++) tx_one(8'(b), 0);
    // R1 other divisors
    baud_div = 8'd3;
    tx_one(8'hA5, 3);
    tx_one(8'h3C, 3);
    baud_div = 8'd0;

    // R12 transmit-complete request
    ie_txd = 1'b1; gie = 1'b1; @(negedge clk);
    check("R12 irq_txd", {31'd0, irq_txd}, 32'd1);
    ie_txd = 1'b0; @(negedge clk);
    check("R12 irq_txd disabled", {31'd0, irq_txd}, 32'd0);

    // R4 back-to-back write
    tx_data = 8'h11; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    check("R5 tx_done cleared by write", {31'd0, tx_done}, 32'd0);
    repeat (20) @(negedge clk);
    tx_data = 8'hC6; tx_valid = 1'b1;
    @(negedge clk); tx_valid = 1'b0;
    check("R4 tx_ready low while held", {31'd0, tx_ready}, 32'd0);
    repeat (160 - 22) @(negedge clk);
    check("R4 still held before boundary", {30'd0, tx_ready, txd}, 32'd1);
    @(negedge clk);
    check("R4 next start with no gap", {29'd0, txd, tx_ready, tx_done}, 32'd2);
    grab_frame(0, bits);
    check("R4 held byte frame", {22'd0, bits}, {22'd0, 1'b1, 8'hC6, 1'b0});

    // R6 R9 receive sweep with one-clock glitch in every bit
    for (int b = 0; b < 256; b++) begin
      rx_one(8'(b), 0, 1'b1, 1'b0);
      check("R6 rx_valid", {31'd0, rx_valid}, 32'd1);
      check("R6 rx_data", {24'd0, rx_data}, {24'd0, 8'(b)});
      check("R8 no framing error", {31'd0, rx_ferr}, 32'd0);
      rd_pulse();
      check("R9 read clears valid", {31'd0, rx_valid}, 32'd0);
    end
    baud_div = 8'd2;
    rx_one(8'h96, 2, 1'b1, 1'b0);
    check("R6 rx divisor 2", {23'd0, rx_valid, rx_data}, {23'd0, 1'b1, 8'h96});
    // R9 hold without ready
    repeat (50) @(negedge clk);
    check("R9 byte held", {23'd0, rx_valid, rx_data}, {23'd0, 1'b1, 8'h96});
    // R12 receive request
    ie_rx = 1'b1; @(negedge clk);
    check("R12 irq_rx", {31'd0, irq_rx}, 32'd1);
    gie = 1'b0; @(negedge clk);
    check("R12 irq_rx global off", {31'd0, irq_rx}, 32'd0);
    rd_pulse();
    baud_div = 8'd0;

    // R8 framing error
    rx_one(8'h5A, 0, 1'b0, 1'b1);
    check("R8 ferr with byte", {22'd0, rx_ferr, rx_valid, rx_data}, {22'd0, 2'b11, 8'h5A});
    rd_pulse();
    check("R8 ferr cleared on read", {30'd0, rx_ferr, rx_valid}, 32'd0);

    // R7 short start pulse rejected
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (200) @(negedge clk);
    check("R7 false start ignored", {31'd0, rx_valid}, 32'd0);
    rx_one(8'h7E, 0, 1'b0, 1'b0);
    check("R7 recovers after reject", {23'd0, rx_valid, rx_data}, {23'd0, 1'b1, 8'h7E});

    // R10 overrun, R11 two-step clear
    rx_one(8'h81, 0, 1'b0, 1'b0);
    check("R10 overrun set", {31'd0, rx_ovr}, 32'd1);
    check("R10 newer byte kept", {24'd0, rx_data}, 32'h81);
    rd_pulse();
    check("R11 plain read keeps ovr", {30'd0, rx_ovr, rx_valid}, 32'd2);
    rx_one(8'h42, 0, 1'b0, 1'b0);
    check("R11 no new overrun", {30'd0, rx_ovr, rx_valid}, 32'd3);
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    check("R11 status read alone keeps ovr", {31'd0, rx_ovr}, 32'd1);
    rd_pulse();
    check("R11 ovr cleared", {30'd0, rx_ovr, rx_valid}, 32'd0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule